// File: doc/BRIEF.md
# Prescaled Down-Counter Timer Channel

This block is one 32-bit timer channel that counts down from a programmable start value. A clock prescaler sets the counting rate. It produces one decrement for every 1, 16 or 256 enabled clock cycles. When the count arrives at zero, the block raises a single-cycle terminal pulse. In periodic mode the count then restarts from the active reload value. In one-shot mode the count parks at zero until software loads it again.

Software has two ways to change the reload value. A direct load replaces the reload value and the running count at once, and it restarts the prescaler. A background write changes nothing visible at first. It holds the new value as pending. The pending value becomes the active reload value only at the next terminal count, so the current period runs to its end undisturbed. The `reload_val` output always shows the active value, never the pending one. A read of the background location therefore returns the active value.

Top module: `tmr_channel`

## Requirements
- R1: While reset is asserted and right after it, `count` and `reload_val` are 0xFFFFFFFF, `tc_pulse` is 0, and the divide ratio is 1.
- R2: `psc_code` sets the divide ratio: 2'b00 gives 1, 2'b01 gives 16, 2'b10 gives 256. The count drops by one after each such number of cycles with `run_en` high. A new code takes effect one clock edge after it is applied.
- R3: Code 2'b11 leaves the previous divide ratio in force, and `psc_err` is high in every cycle in which `psc_code` is 2'b11.
- R4: A cycle with `load_we` high sets `count` and `reload_val` to `load_data` at the next edge and restarts the prescaler phase. The load takes priority over a tick in that same cycle.
- R5: A tick with `count` equal to 1 brings `count` to 0, and `tc_pulse` is high for exactly that one following cycle. This holds in both modes.
- R6: In periodic mode (`one_shot`=0), a tick with `count` at 0 loads `count` from the active reload value, so one period lasts reload+1 ticks.
- R7: In one-shot mode (`one_shot`=1), `count` stays at 0 after the terminal pulse, with no further pulses, until a load write.
- R8: A `bg_we` write stores `bg_data` as pending and leaves `reload_val` and `count` unchanged. At the next terminal count the pending value becomes `reload_val`.
- R9: While `run_en` is low and no load is written, `count` and the prescaler phase hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counting enable |
| one_shot | input | 1 | 1 selects one-shot, 0 selects periodic |
| psc_code | input | 2 | Prescaler select code |
| load_we | input | 1 | Immediate load strobe |
| load_data | input | 32 | Immediate load value |
| bg_we | input | 1 | Background reload strobe |
| bg_data | input | 32 | Background reload value |
| count | output | 32 | Current count |
| reload_val | output | 32 | Active reload value |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| psc_err | output | 1 | Undefined prescaler code present |

## Verification
The channel runs with small load values at each of the three divide ratios. The spacing of decrements tells the ratios apart. The pulse spacing tells a reload+1 period apart from an off-by-one period. Next comes the undefined code, applied after a divide-by-16 setting. Counting must go on at 16 cycles per tick; a ratio that silently dropped to 1 would show. A background write placed in mid-period must leave the visible reload unchanged until the pulse. One-shot runs, enable gaps and a load in mid-count show apart parking, holding and restart-on-load behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    DIV1   = 2'b00,
    DIV16  = 2'b01,
    DIV256 = 2'b10,
    DIVBAD = 2'b11
  } div_code_e;

  localparam int unsigned PSC_W = 8;

  // last phase value before a tick for each ratio (ratio - 1)
  function automatic logic [PSC_W-1:0] div_last(div_code_e c);
    case (c)
      DIV16:   div_last = PSC_W'(15);
      DIV256:  div_last = PSC_W'(255);
      default: div_last = '0;
    endcase
  endfunction

  function automatic logic code_valid(logic [1:0] c);
    code_valid = (c != 2'b11);
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       restart,
  input  logic [1:0] psc_code,
  output logic       tick,
  output logic       psc_err
);

  div_code_e        div_q;
  logic [PSC_W-1:0] phase_q;
  logic             at_last;

  assign psc_err = ~code_valid(psc_code);
  assign at_last = (phase_q >= div_last(div_q));
  assign tick    = run_en & ~restart & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   div_q <= DIV1;
    else if (code_valid(psc_code)) div_q <= div_code_e'(psc_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run_en)  phase_q <= at_last ? '0 : phase_q + 1'b1;
  end

  // R3: undefined code keeps the ratio in force
  a_r3_keep_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    psc_err |=> $stable(div_q));

  // R9: phase frozen while disabled
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !restart) |=> $stable(phase_q));

  // R4: load restarts the prescaler phase
  a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));

endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             bg_we,
  input  logic [CNT_W-1:0] bg_data,
  input  logic             tc_evt,
  output logic [CNT_W-1:0] reload_q
);

  logic [CNT_W-1:0] pend_val_q;
  logic             pend_q;
  logic             apply_pend;

  assign apply_pend = tc_evt & pend_q & ~load_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          reload_q <= '1;
    else if (load_we)    reload_q <= load_data;
    else if (apply_pend) reload_q <= pend_val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_val_q <= '1;
    end else if (bg_we) begin
      pend_q     <= 1'b1;
      pend_val_q <= bg_data;
    end else if (tc_evt) begin
      pend_q     <= 1'b0;
    end
  end

  // R8: pending value becomes active at terminal count
  a_r8_bg_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && pend_q && !load_we) |=> (reload_q == $past(pend_val_q)));

  // R8: without load or terminal count, active reload is untouched
  a_r8_bg_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_evt && !load_we) |=> $stable(reload_q));

  // R4: load replaces reload immediately
  a_r4_reload_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (reload_q == $past(load_data)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             tick,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output logic             tc_evt,
  output logic             tc_pulse
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;
  logic at_one;

  assign at_zero = (count_q == '0);
  assign at_one  = (count_q == ONE);
  assign tc_evt  = tick & at_one & ~load_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '1;
    else if (load_we) count_q <= load_data;
    else if (tick) begin
      if (!at_zero)      count_q <= count_q - 1'b1;
      else if (!one_shot) count_q <= reload_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_pulse <= 1'b0;
    else        tc_pulse <= tc_evt;
  end

  // R5: the pulse coincides with a zero count
  a_r5_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (count_q == '0));

  // R7: one-shot parks at zero
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && one_shot && !load_we) |=> (count_q == '0));

  // R6: periodic wrap takes the active reload
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !one_shot && !load_we) |=> (count_q == $past(reload_q)));

  // R9: no tick, no load means no change
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_we) |=> $stable(count_q));

  // R4: load sets the count
  a_r4_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count_q == $past(load_data)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             one_shot,
  input  logic [1:0]       psc_code,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             bg_we,
  input  logic [CNT_W-1:0] bg_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload_val,
  output logic             tc_pulse,
  output logic             psc_err
);

  logic tick;
  logic tc_evt;

  tmr_prescaler u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .restart  (load_we),
    .psc_code (psc_code),
    .tick     (tick),
    .psc_err  (psc_err)
  );

  tmr_reload #(.CNT_W(CNT_W)) u_rld (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (load_we),
    .load_data (load_data),
    .bg_we     (bg_we),
    .bg_data   (bg_data),
    .tc_evt    (tc_evt),
    .reload_q  (reload_val)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (load_we),
    .load_data (load_data),
    .tick      (tick),
    .one_shot  (one_shot),
    .reload_q  (reload_val),
    .count_q   (count),
    .tc_evt    (tc_evt),
    .tc_pulse  (tc_pulse)
  );

  // R5: terminal pulse never lasts two cycles without a reload of 0 or load
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !load_we) |=> !tc_pulse);

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        one_shot = 1'b0;
  logic [1:0]  psc_code = 2'b00;
  logic        load_we = 1'b0;
  logic [31:0] load_data = '0;
  logic        bg_we = 1'b0;
  logic [31:0] bg_data = '0;
  logic [31:0] count;
  logic [31:0] reload_val;
  logic        tc_pulse;
  logic        psc_err;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] cnt;
    logic [31:0] rel;
    logic        tc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  // model state
  logic [31:0] m_cnt = 32'hFFFF_FFFF;
  logic [31:0] m_rel = 32'hFFFF_FFFF;
  logic [31:0] m_pval = 32'hFFFF_FFFF;
  bit          m_pend = 1'b0;
  int unsigned m_ratio = 1;
  int unsigned m_elapsed = 0;

  always #10 clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .one_shot(one_shot),
    .psc_code(psc_code), .load_we(load_we), .load_data(load_data),
    .bg_we(bg_we), .bg_data(bg_data), .count(count),
    .reload_val(reload_val), .tc_pulse(tc_pulse), .psc_err(psc_err)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "count", count, e.cnt);
      check(e.tag, "reload_val", reload_val, e.rel);
      check(e.tag, "tc_pulse", {31'b0, tc_pulse}, {31'b0, e.tc});
    end
  end

  // driver: one cycle of stimulus plus its expected outcome
  task automatic step(input bit en, input bit os, input bit [1:0] code,
                      input bit lwe, input logic [31:0] ld,
                      input bit bwe, input logic [31:0] bd, input string tag);
    bit   tick;
    bit   term;
    exp_t e;
    @(negedge clk);
    run_en = en; one_shot = os; psc_code = code;
    load_we = lwe; load_data = ld; bg_we = bwe; bg_data = bd;
    tick = en && !lwe && (m_elapsed + 1 >= m_ratio);
    term = tick && (m_cnt == 32'd1);
    if (lwe)      m_elapsed = 0;
    else if (en)  m_elapsed = tick ? 0 : m_elapsed + 1;
    if (lwe) m_rel = ld;
    else if (term && m_pend) m_rel = m_pval;
    if (bwe) begin m_pend = 1'b1; m_pval = bd; end
    else if (term) m_pend = 1'b0;
    if (lwe) m_cnt = ld;
    else if (tick) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (!os)   m_cnt = m_rel;
    end
    if (code != 2'b11) m_ratio = 1 << (4 * code);
    e.cnt = m_cnt; e.rel = m_rel; e.tc = term; e.tag = tag;
    sb_q.push_back(e);
    #1;
    check("R3", "psc_err", {31'b0, psc_err}, {31'b0, (code == 2'b11)});
  endtask

  task automatic run(input int n, input bit en, input bit os,
                     input bit [1:0] code, input string tag);
    for (int i = 0; i < n; i++) step(en, os, code, 0, '0, 0, '0, tag);
  endtask

  task automatic load(input logic [31:0] v, input bit os,
                      input bit [1:0] code, input string tag);
    step(1, os, code, 1, v, 0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "reset count", count, 32'hFFFF_FFFF);
    check("R1", "reset reload", reload_val, 32'hFFFF_FFFF);
    check("R1", "reset tc", {31'b0, tc_pulse}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first ticks after reset at ratio 1
    run(3, 1, 0, 2'b00, "R1");
    // R5 R6: periodic at ratio 1
    load(32'd3, 0, 2'b00, "R4");
    run(12, 1, 0, 2'b00, "R6");
    // R8: background write mid-period
    step(1, 0, 2'b00, 0, '0, 1, 32'd5, "R8");
    run(14, 1, 0, 2'b00, "R8");
    // R2: ratio 16
    load(32'd2, 0, 2'b01, "R2");
    run(60, 1, 0, 2'b01, "R2");
    // R3: undefined code keeps ratio 16
    run(50, 1, 0, 2'b11, "R3");
    // R2: ratio 256
    load(32'd1, 0, 2'b10, "R2");
    run(1100, 1, 0, 2'b10, "R2");
    // R7: one-shot
    load(32'd2, 1, 2'b00, "R7");
    run(10, 1, 1, 2'b00, "R7");
    // R9: enable gaps
    load(32'd6, 0, 2'b01, "R9");
    run(20, 1, 0, 2'b01, "R9");
    run(40, 0, 0, 2'b01, "R9");
    run(20, 1, 0, 2'b01, "R9");
    // R4: load mid-count restarts
    run(7, 1, 0, 2'b01, "R4");
    load(32'd4, 0, 2'b00, "R4");
    run(8, 1, 0, 2'b00, "R4");
    // R5: pulse in one-shot after a background write is applied
    step(1, 1, 2'b00, 0, '0, 1, 32'd9, "R5");
    load(32'd2, 1, 2'b00, "R5");
    run(6, 1, 1, 2'b00, "R5");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule